// File: doc/BRIEF.md
# Receive RTS Flow Control with Hysteresis

This block generates an active-low request-to-send line for a serial receiver. It watches the fill level of a 128-entry receive FIFO and tells the remote transmitter to pause or resume. The count arrives as a plain input and is registered inside the block.

Three levels are compared against that count. The data-ready trigger raises an interrupt, but it leaves the request line active. The request is withdrawn only when the count climbs to the upper threshold. It is restored only when software drains the FIFO down to the lower threshold, so the FIFO keeps filling past the interrupt point.

Automatic pacing requires an enable bit, and it begins only after software has asserted its own RTS request. With the enable clear, the line simply mirrors that software request. An optional flag records each rising edge of `rts_n`, meaning each time RTS turns off. The flag is set only when both its own enable and the enhanced-function enable are set, and a status-read strobe clears it.

Top module: `rx_rts_hyst`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rts_n` is 1, and `rx_rdy_irq` and `rts_irq` are 0.
- R2: With `auto_en`=0, `rts_n` equals the inverse of `sw_rts`, one clock after `sw_rts` is sampled.
- R3: With `auto_en`=1 and `sw_rts`=0, `rts_n` stays 1 at every occupancy. Automatic pacing starts only once `sw_rts` is 1.
- R4: `fill_cnt` is registered before comparison, so a change of occupancy shows on `rts_n` and `rx_rdy_irq` two clocks after it is driven.
- R5: `rx_rdy_irq` is 1 exactly when the registered occupancy is at or above `trig_lvl`. Reaching the trigger level alone does not raise `rts_n`.
- R6: In automatic mode with `sw_rts`=1, `rts_n` goes to 1 when the registered occupancy is at or above `hi_lvl`. That includes an occupancy exactly equal to `hi_lvl`.
- R7: In automatic mode, an occupancy strictly between `lo_lvl` and `hi_lvl` leaves `rts_n` unchanged. `rts_n` stays 1 while the FIFO fills on to its full count of 128.
- R8: In automatic mode with RTS off, `rts_n` returns to 0 when the registered occupancy is at or below `lo_lvl`, including exactly equal. If the occupancy also meets `hi_lvl`, RTS stays off.
- R9: One clock after `rts_n` rises from 0 to 1, `rts_irq` is set, but only if `rts_irq_en` and `enh_en` are both 1. Otherwise `rts_irq` stays 0.
- R10: `stat_rd` clears `rts_irq` at the next clock. A new rising edge in that same cycle wins and sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_cnt | input | 8 | Receive FIFO occupancy (0..128) |
| trig_lvl | input | 8 | Data-ready trigger level |
| hi_lvl | input | 8 | Upper threshold: RTS off |
| lo_lvl | input | 8 | Lower threshold: RTS back on |
| auto_en | input | 1 | Automatic pacing enable |
| sw_rts | input | 1 | Software RTS request (1 = assert RTS) |
| rts_irq_en | input | 1 | RTS-change interrupt enable |
| enh_en | input | 1 | Enhanced-function enable gating `rts_irq_en` |
| stat_rd | input | 1 | Status read strobe, clears `rts_irq` |
| rts_n | output | 1 | Active-low request to send |
| rx_rdy_irq | output | 1 | Receive data-ready interrupt |
| rts_irq | output | 1 | RTS-change interrupt flag |

## Verification
The bench builds the block at its default depth of 128, which makes the count 8 bits wide. It drives a trigger of 16, an upper threshold of 24 and a lower threshold of 8. With these values the bench can reach the following cases with short stimulus:
- an occupancy exactly on each threshold;
- a completely full FIFO at 128;
- a walk through the hysteresis band in both directions.

It can also switch between manual and automatic modes in the middle of a pause.

// File: rtl/rts_hyst_pkg.sv
package rts_hyst_pkg;
  typedef struct packed {
    logic ge_trig;
    logic ge_hi;
    logic le_lo;
  } lvl_cmp_t;
endpackage

// File: rtl/rts_lvl_cmp.sv
module rts_lvl_cmp
  import rts_hyst_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] fill_cnt,
  input  logic [CW-1:0] trig_lvl,
  input  logic [CW-1:0] hi_lvl,
  input  logic [CW-1:0] lo_lvl,
  output lvl_cmp_t      cmp
);
  logic [CW-1:0] fill_q;

  always_ff @(posedge clk) begin
    if (rst) fill_q <= '0;
    else     fill_q <= fill_cnt;
  end

  always_comb begin
    cmp.ge_trig = (fill_q >= trig_lvl);
    cmp.ge_hi   = (fill_q >= hi_lvl);
    cmp.le_lo   = (fill_q <= lo_lvl);
  end
endmodule

// File: rtl/rts_ctl.sv
module rts_ctl
  import rts_hyst_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     auto_en,
  input  logic     sw_rts,
  input  lvl_cmp_t cmp,
  output logic     rts_n
);
  logic paused, paused_nx, armed;

  assign armed = auto_en && sw_rts;

  always_comb begin
    paused_nx = paused;
    if (!armed)          paused_nx = 1'b0;
    else if (cmp.ge_hi)  paused_nx = 1'b1;
    else if (cmp.le_lo)  paused_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      paused <= 1'b0;
      rts_n  <= 1'b1;
    end else begin
      paused <= paused_nx;
      rts_n  <= !(sw_rts && !(auto_en && paused_nx));
    end
  end

  // R2
  manual_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!auto_en) && !$past(rst)) |-> (rts_n == !$past(sw_rts)));

  // R3
  sw_off_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!sw_rts) |-> rts_n);

  // R6
  hi_off_chk: assert property (@(posedge clk) disable iff (rst)
    $past(armed && cmp.ge_hi) |-> rts_n);

  // R8
  lo_on_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(armed && !cmp.ge_hi && cmp.le_lo) && !$past(rst)) |-> !rts_n);
endmodule

// File: rtl/rts_irq_unit.sv
module rts_irq_unit (
  input  logic clk,
  input  logic rst,
  input  logic ge_trig,
  input  logic rts_n,
  input  logic rts_irq_en,
  input  logic enh_en,
  input  logic stat_rd,
  output logic rx_rdy_irq,
  output logic rts_irq
);
  logic rts_n_d, rise;

  assign rise = rts_n && !rts_n_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      rts_n_d    <= 1'b1;
      rx_rdy_irq <= 1'b0;
      rts_irq    <= 1'b0;
    end else begin
      rts_n_d    <= rts_n;
      rx_rdy_irq <= ge_trig;
      if (rise && rts_irq_en && enh_en) rts_irq <= 1'b1;
      else if (stat_rd)                 rts_irq <= 1'b0;
    end
  end

  // R5
  rdy_level_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rx_rdy_irq == $past(ge_trig)));

  // R9
  rts_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(rts_n) && rts_irq_en && enh_en) |=> rts_irq);

  // R9
  gate_chk: assert property (@(posedge clk) disable iff (rst)
    !(rts_irq_en && enh_en) |=> !$rose(rts_irq));

  // R10
  stat_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !(rise && rts_irq_en && enh_en)) |=> !rts_irq);
endmodule

// File: rtl/rx_rts_hyst.sv
module rx_rts_hyst
  import rts_hyst_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] fill_cnt,
  input  logic [CW-1:0] trig_lvl,
  input  logic [CW-1:0] hi_lvl,
  input  logic [CW-1:0] lo_lvl,
  input  logic          auto_en,
  input  logic          sw_rts,
  input  logic          rts_irq_en,
  input  logic          enh_en,
  input  logic          stat_rd,
  output logic          rts_n,
  output logic          rx_rdy_irq,
  output logic          rts_irq
);
  lvl_cmp_t cmp;

  rts_lvl_cmp #(.CW(CW)) u_cmp (
    .clk(clk), .rst(rst), .fill_cnt(fill_cnt), .trig_lvl(trig_lvl),
    .hi_lvl(hi_lvl), .lo_lvl(lo_lvl), .cmp(cmp)
  );

  rts_ctl u_ctl (
    .clk(clk), .rst(rst), .auto_en(auto_en), .sw_rts(sw_rts),
    .cmp(cmp), .rts_n(rts_n)
  );

  rts_irq_unit u_irq (
    .clk(clk), .rst(rst), .ge_trig(cmp.ge_trig), .rts_n(rts_n),
    .rts_irq_en(rts_irq_en), .enh_en(enh_en), .stat_rd(stat_rd),
    .rx_rdy_irq(rx_rdy_irq), .rts_irq(rts_irq)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (rts_n && !rx_rdy_irq && !rts_irq));
endmodule

// File: tb/test_rx_rts_hyst.sv
module test_rx_rts_hyst;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] fill_cnt = '0;
  logic [7:0] trig_lvl = 8'd16, hi_lvl = 8'd24, lo_lvl = 8'd8;
  logic auto_en = 1'b0, sw_rts = 1'b0, rts_irq_en = 1'b0, enh_en = 1'b0, stat_rd = 1'b0;
  logic rts_n, rx_rdy_irq, rts_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_rts_hyst i_rx_rts_hyst (
    .clk(clk), .rst(rst), .fill_cnt(fill_cnt), .trig_lvl(trig_lvl),
    .hi_lvl(hi_lvl), .lo_lvl(lo_lvl), .auto_en(auto_en), .sw_rts(sw_rts),
    .rts_irq_en(rts_irq_en), .enh_en(enh_en), .stat_rd(stat_rd),
    .rts_n(rts_n), .rx_rdy_irq(rx_rdy_irq), .rts_irq(rts_irq)
  );

  // {fill, auto_en, sw_rts, exp rts_n, exp rx_rdy_irq}
  localparam logic [11:0] VEC [15] = '{
    {8'd0,   1'b1, 1'b0, 1'b1, 1'b0},  // R3 not started
    {8'd0,   1'b1, 1'b1, 1'b0, 1'b0},  // R3 started
    {8'd15,  1'b1, 1'b1, 1'b0, 1'b0},  // R5 below trigger
    {8'd16,  1'b1, 1'b1, 1'b0, 1'b1},  // R5 trigger, RTS stays on
    {8'd23,  1'b1, 1'b1, 1'b0, 1'b1},  // R7 band
    {8'd24,  1'b1, 1'b1, 1'b1, 1'b1},  // R6 exactly upper
    {8'd128, 1'b1, 1'b1, 1'b1, 1'b1},  // R7 full
    {8'd16,  1'b1, 1'b1, 1'b1, 1'b1},  // R7 hold off
    {8'd9,   1'b1, 1'b1, 1'b1, 1'b0},  // R7 hold off
    {8'd8,   1'b1, 1'b1, 1'b0, 1'b0},  // R8 exactly lower
    {8'd20,  1'b1, 1'b1, 1'b0, 1'b1},  // R7 hold on
    {8'd24,  1'b1, 1'b1, 1'b1, 1'b1},  // R6
    {8'd24,  1'b0, 1'b1, 1'b0, 1'b1},  // R2 manual on
    {8'd24,  1'b0, 1'b0, 1'b1, 1'b1},  // R2 manual off
    {8'd24,  1'b1, 1'b1, 1'b1, 1'b1}   // R6 re-arm above upper
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_chk++; n_fail++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
          $finish;
        end
      end
    join_none
  end

  initial begin
    edges(3);
    chk("R1 rts_n", rts_n, 1'b1);
    chk("R1 rx_rdy_irq", rx_rdy_irq, 1'b0);
    chk("R1 rts_irq", rts_irq, 1'b0);
    rst = 1'b0;
    edges(1);
    chk("R1 after release", rts_n, 1'b1);

    for (int i = 0; i < 15; i++) begin
      fill_cnt = VEC[i][11:4];
      auto_en  = VEC[i][3];
      sw_rts   = VEC[i][2];
      edges(2);
      chk($sformatf("R4 vec%0d rts_n", i), rts_n, VEC[i][1]);
      chk($sformatf("R4 vec%0d rx_rdy_irq", i), rx_rdy_irq, VEC[i][0]);
    end
    chk("R9 no enable", rts_irq, 1'b0);

    // R4 latency: one clock is not enough for occupancy to reach rts_n
    fill_cnt = 8'd8;
    edges(1);
    chk("R4 one clock", rts_n, 1'b1);
    edges(1);
    chk("R4 two clocks", rts_n, 1'b0);

    // R9 only irq enable, not enhanced
    rts_irq_en = 1'b1;
    auto_en = 1'b0; sw_rts = 1'b0;
    edges(3);
    chk("R9 enh gate rts_n", rts_n, 1'b1);
    chk("R9 enh gate", rts_irq, 1'b0);

    // R9 both enables
    enh_en = 1'b1; sw_rts = 1'b1;
    edges(2);
    chk("R2 on", rts_n, 1'b0);
    sw_rts = 1'b0;
    edges(1);
    chk("R2 off", rts_n, 1'b1);
    edges(1);
    chk("R9 flag set", rts_irq, 1'b1);

    // R10 clear
    stat_rd = 1'b1;
    edges(1);
    stat_rd = 1'b0;
    chk("R10 cleared", rts_irq, 1'b0);

    // R10 set wins over clear
    sw_rts = 1'b1;
    edges(2);
    sw_rts = 1'b0;
    edges(1);
    stat_rd = 1'b1;
    edges(1);
    stat_rd = 1'b0;
    chk("R10 set wins", rts_irq, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule